// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two radix-2 signed-digit operands of `N` digits each, with `N` = 4 by default, and returns an `N+1`-digit signed-digit sum. Each digit is a two-bit code whose value is -1, 0 or +1. Digit `k` has weight 2^k, and the number's value is the weighted sum of its digits, so no separate sign bit exists. Zero has two codes, which makes the representation redundant. This redundancy is what allows the addition to finish without a carry chain.

Every position splits its digit sum into a transfer digit, which goes to the next position up, and an interim digit, which stays. The split satisfies `x + y = 2*t + w`. Each output digit is the interim digit plus the transfer from the position below. At an odd digit sum, the split chooses between two forms by looking at the sign of the digits one position lower. This choice keeps every output digit inside {-1, 0, +1}. Each output digit therefore depends on at most three input positions, and the logic depth does not grow with `N`. A helper output gives the sum's two's-complement value for checking and for consumers that need binary.

Top module: `rbsd_adder`

## Requirements
- R1: Input digit codes decode as 00 = -1, 01 = 0, 10 = 0 and 11 = +1. The two zero codes produce identical outputs.
- R2: The weighted value of `sum_dig` equals the weighted value of `x_dig` plus the weighted value of `y_dig`, for every combination of input codes.
- R3: Every output digit is -1, 0 or +1. Zero is always emitted as code 01, and code 10 never appears on `sum_dig`.
- R4: Position i forms a transfer digit t and an interim digit w from the digit sum p, with p = 2t + w. The rules are:
  - p = +2 gives t = +1, w = 0.
  - p = -2 gives t = -1, w = 0.
  - p = 0 gives t = 0, w = 0.
  - p = +1 gives t = +1, w = -1 when both digits at position i-1 are non-negative, and t = 0, w = +1 otherwise.
  - p = -1 gives t = 0, w = -1 when both digits at position i-1 are non-negative, and t = -1, w = +1 otherwise.
  - Position 0 treats its missing lower digits as non-negative.
  - Output digit i is w_i + t_(i-1), with t_(-1) = 0.
- R5: Top digit `sum_dig[2N+1:2N]` equals the transfer digit of position N-1. It is +1 only when the top input digits sum to a positive value, and -1 only when they sum to a negative value.
- R6: `sum_val` is the (N+2)-bit two's-complement value of `sum_dig`.
- R7: Operands 6 (codes 01 11 11 01, msb first) and 5 (01 11 01 11) give `sum_val` = 11 and, msb first, digits 0, +1, +1, 0, -1 (`sum_dig` = 10'b0111110100).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_dig | input | 2*N | First operand, digit k in bits [2k+1:2k] |
| y_dig | input | 2*N | Second operand, same layout |
| sum_dig | output | 2*N+2 | Signed-digit sum, N+1 digits, same layout |
| sum_val | output | N+2 | Two's-complement value of the sum |

## Verification
The hardest case to reach is the odd digit sum whose split depends on the position below. A wrong choice there shows up only when the neighbour's transfer has the matching sign and pushes an output digit to ±2, or to a disallowed code. The stimulus sweeps every code of every digit for both operands. This covers all 65,536 combinations, including every mix of the two zero codes. Every odd-sum position therefore meets every possible lower neighbour.

// File: rtl/rbsd_pkg.sv
// Package rbsd_pkg: digit codes and conversions for the signed-digit adder.
// Assumes a digit code is two bits; digit values are held as 2-bit signed.
package rbsd_pkg;

    typedef logic [1:0]        sd_code_t;
    typedef logic signed [1:0] sd_val_t;

    localparam sd_code_t CODE_NEG  = 2'b00;
    localparam sd_code_t CODE_ZERO = 2'b01;
    localparam sd_code_t CODE_ZALT = 2'b10;
    localparam sd_code_t CODE_POS  = 2'b11;

    localparam sd_val_t VAL_M1 = 2'sb11;
    localparam sd_val_t VAL_Z  = 2'sb00;
    localparam sd_val_t VAL_P1 = 2'sb01;

    // Map a code to its digit value; both zero codes give 0.
    function automatic sd_val_t sd_decode(input sd_code_t c);
        case (c)
            CODE_NEG: return VAL_M1;
            CODE_POS: return VAL_P1;
            default:  return VAL_Z;
        endcase
    endfunction

    // Map a digit value to its canonical code; zero is always 01.
    function automatic sd_code_t sd_encode(input sd_val_t v);
        case (v)
            VAL_M1:  return CODE_NEG;
            VAL_P1:  return CODE_POS;
            default: return CODE_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/rbsd_split.sv
// Module rbsd_split: splits one position's digit sum into a transfer digit
// and an interim digit. Odd sums look at the lower position's digits so that
// the later merge can never leave the digit range.
// Assumes lo_x/lo_y are tied to the zero code at position 0.
module rbsd_split
    import rbsd_pkg::*;
(
    input  sd_code_t x_code,
    input  sd_code_t y_code,
    input  sd_code_t lo_x_code,
    input  sd_code_t lo_y_code,
    output sd_val_t  xfer,
    output sd_val_t  interim
);

    logic signed [2:0] psum;
    logic              lo_nonneg;
    sd_val_t           xv;
    sd_val_t           yv;

    // Digit sum and the sign class of the position below.
    always_comb begin
        xv        = sd_decode(x_code);
        yv        = sd_decode(y_code);
        psum      = {xv[1], xv} + {yv[1], yv};
        lo_nonneg = (lo_x_code != CODE_NEG) && (lo_y_code != CODE_NEG);
    end

    // Select transfer and interim digits so that psum = 2*xfer + interim.
    always_comb begin
        xfer    = VAL_Z;
        interim = VAL_Z;
        case (psum)
            3'sb010: xfer = VAL_P1;
            3'sb110: xfer = VAL_M1;
            3'sb001: begin
                if (lo_nonneg) begin
                    xfer    = VAL_P1;
                    interim = VAL_M1;
                end else begin
                    interim = VAL_P1;
                end
            end
            3'sb111: begin
                if (lo_nonneg) begin
                    interim = VAL_M1;
                end else begin
                    xfer    = VAL_M1;
                    interim = VAL_P1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rbsd_merge.sv
// Module rbsd_merge: adds an interim digit and the incoming transfer digit
// and emits the result as a canonical code.
// Assumes the split rule keeps the total within -1..+1 (no new transfer).
module rbsd_merge
    import rbsd_pkg::*;
(
    input  sd_val_t  interim,
    input  sd_val_t  xfer_in,
    output sd_code_t sum_code
);

    logic signed [2:0] total;

    // Sum the two digits and encode the low two bits of the result.
    always_comb begin
        total    = {interim[1], interim} + {xfer_in[1], xfer_in};
        sum_code = sd_encode(total[1:0]);
    end

endmodule

// File: rtl/rbsd_value.sv
// Module rbsd_value: weighted sum of D signed digits into a two's-complement
// value of D+1 bits. Used for checking and for binary consumers.
// Assumes digit k sits in bits [2k+1:2k].
module rbsd_value
    import rbsd_pkg::*;
#(
    parameter int D = 5
) (
    input  logic [2*D-1:0]    digits,
    output logic signed [D:0] value
);

    localparam int VW = D + 1;

    // Accumulate +/- 2^k for each nonzero digit.
    always_comb begin
        value = '0;
        for (int k = 0; k < D; k++) begin
            case (digits[2*k +: 2])
                CODE_POS: value = value + (VW'(1) << k);
                CODE_NEG: value = value - (VW'(1) << k);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/rbsd_adder.sv
// Module rbsd_adder: carry-free adder of two N-digit signed-digit operands.
// Each position splits, then merges with the transfer from below; no chain
// runs across the word. Output has N+1 digits plus a binary value.
// Assumes purely combinational use; the caller registers around it.
module rbsd_adder
    import rbsd_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [2*N-1:0]      x_dig,
    input  logic [2*N-1:0]      y_dig,
    output logic [2*N+1:0]      sum_dig,
    output logic signed [N+1:0] sum_val
);

    localparam int OD = N + 1;

    sd_val_t xfer    [N];
    sd_val_t interim [N];

    for (genvar i = 0; i < N; i++) begin : g_pos
        sd_code_t lo_x;
        sd_code_t lo_y;
        sd_val_t  t_in;

        if (i == 0) begin : g_base
            // Lowest position: no lower digits and no incoming transfer.
            assign lo_x = CODE_ZERO;
            assign lo_y = CODE_ZERO;
            assign t_in = VAL_Z;
        end else begin : g_upper
            // Other positions: look one position down.
            assign lo_x = x_dig[2*(i-1) +: 2];
            assign lo_y = y_dig[2*(i-1) +: 2];
            assign t_in = xfer[i-1];
        end

        rbsd_split i_split (
            .x_code    (x_dig[2*i +: 2]),
            .y_code    (y_dig[2*i +: 2]),
            .lo_x_code (lo_x),
            .lo_y_code (lo_y),
            .xfer      (xfer[i]),
            .interim   (interim[i])
        );

        rbsd_merge i_merge (
            .interim  (interim[i]),
            .xfer_in  (t_in),
            .sum_code (sum_dig[2*i +: 2])
        );
    end

    // Top digit is the transfer out of the highest position.
    assign sum_dig[2*N +: 2] = sd_encode(xfer[N-1]);

    rbsd_value #(.D(OD)) i_value (
        .digits (sum_dig),
        .value  (sum_val)
    );

endmodule

// File: rtl/rbsd_adder_chk.sv
// Module rbsd_adder_chk: assertions on the adder's ports, bound to rbsd_adder.
module rbsd_adder_chk
    import rbsd_pkg::*;
#(
    parameter int N = 4
) (
    input logic [2*N-1:0]      x_dig,
    input logic [2*N-1:0]      y_dig,
    input logic [2*N+1:0]      sum_dig,
    input logic signed [N+1:0] sum_val
);

    function automatic int weigh(input logic [2*N+1:0] d, input int cnt);
        int acc = 0;
        for (int k = 0; k < cnt; k++) begin
            acc += int'(sd_decode(d[2*k +: 2])) * (1 << k);
        end
        return acc;
    endfunction

    // Value, top digit and lowest digit checks against the operands.
    always_comb begin
        int xs;
        int ys;
        int top;
        int low;
        xs  = weigh({2'b01, x_dig}, N);
        ys  = weigh({2'b01, y_dig}, N);
        top = int'(sd_decode(x_dig[2*N-1 -: 2])) + int'(sd_decode(y_dig[2*N-1 -: 2]));
        low = int'(sd_decode(x_dig[1:0])) + int'(sd_decode(y_dig[1:0]));
        // R2
        value_sum_chk: assert (int'(sum_val) == xs + ys)
            else $error("sum value %0d vs %0d", sum_val, xs + ys);
        // R5
        top_sign_chk: assert (!((sum_dig[2*N +: 2] == CODE_POS && top <= 0) ||
                                (sum_dig[2*N +: 2] == CODE_NEG && top >= 0)))
            else $error("top digit sign mismatch");
        // R4
        low_parity_chk: assert ((sum_dig[1:0] != CODE_ZERO) == (low % 2 != 0))
            else $error("lowest digit parity mismatch");
    end

    for (genvar k = 0; k <= N; k++) begin : g_code
        // Each output digit uses the canonical zero code.
        always_comb begin
            // R3
            canon_zero_chk: assert (sum_dig[2*k +: 2] != CODE_ZALT)
                else $error("digit %0d uses alternate zero", k);
        end
    end

endmodule

bind rbsd_adder rbsd_adder_chk #(.N(N)) i_chk (
    .x_dig   (x_dig),
    .y_dig   (y_dig),
    .sum_dig (sum_dig),
    .sum_val (sum_val)
);

// File: tb/test_rbsd_adder.sv
// Bench test_rbsd_adder: sweeps every code combination for N = 4 and compares
// with a behavioural model built from the requirements.
module test_rbsd_adder;

    localparam int N = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [2*N-1:0]         x_dig = {N{2'b01}};
    logic [2*N-1:0]         y_dig = {N{2'b01}};
    logic [2*N+1:0]         sum_dig;
    logic signed [N+1:0]    sum_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    rbsd_adder #(.N(N)) i_rbsd_adder (
        .x_dig   (x_dig),
        .y_dig   (y_dig),
        .sum_dig (sum_dig),
        .sum_val (sum_val)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    function automatic int dval(input logic [1:0] c);
        return (c == 2'b00) ? -1 : (c == 2'b11) ? 1 : 0;
    endfunction

    function automatic logic [1:0] denc(input int v);
        return (v < 0) ? 2'b00 : (v > 0) ? 2'b11 : 2'b01;
    endfunction

    function automatic int wsum(input logic [2*N+1:0] d, input int cnt);
        int acc = 0;
        for (int k = 0; k < cnt; k++) acc += dval(d[2*k +: 2]) * (1 << k);
        return acc;
    endfunction

    // Expected digits from the split and merge rules of R4 and R5.
    function automatic logic [2*N+1:0] model(input logic [2*N-1:0] xa,
                                             input logic [2*N-1:0] ya);
        int t[N];
        int w[N];
        logic [2*N+1:0] r;
        for (int i = 0; i < N; i++) begin
            int  p  = dval(xa[2*i +: 2]) + dval(ya[2*i +: 2]);
            bit  nn = (i == 0) ? 1'b1 :
                      (dval(xa[2*(i-1) +: 2]) >= 0 && dval(ya[2*(i-1) +: 2]) >= 0);
            if (p == 1)       begin t[i] = nn ? 1 : 0;  w[i] = nn ? -1 : 1; end
            else if (p == -1) begin t[i] = nn ? 0 : -1; w[i] = nn ? -1 : 1; end
            else              begin t[i] = p / 2;       w[i] = 0;           end
        end
        for (int i = 0; i < N; i++) r[2*i +: 2] = denc(w[i] + ((i == 0) ? 0 : t[i-1]));
        r[2*N +: 2] = denc(t[N-1]);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (x=%b y=%b)", req, act, exp, x_dig, y_dig);
        end
    endtask

    // Compare all outputs of the current input pair with the model.
    task automatic compare();
        int exp_val = wsum({2'b01, x_dig}, N) + wsum({2'b01, y_dig}, N);
        logic [2*N+1:0] exp_dig = model(x_dig, y_dig);
        bit alt = 1'b0;
        for (int k = 0; k <= N; k++) if (sum_dig[2*k +: 2] == 2'b10) alt = 1'b1;
        check(sum_dig == exp_dig, "R1 R4 digits", int'(sum_dig), int'(exp_dig));
        check(wsum(sum_dig, N + 1) == exp_val, "R2 digit value", wsum(sum_dig, N + 1), exp_val);
        check(!alt, "R3 canonical zero", int'(sum_dig), int'(exp_dig));
        check(sum_dig[2*N +: 2] == exp_dig[2*N +: 2], "R5 top digit",
              int'(sum_dig[2*N +: 2]), int'(exp_dig[2*N +: 2]));
        check(int'(sum_val) == wsum(sum_dig, N + 1), "R6 binary value",
              int'(sum_val), wsum(sum_dig, N + 1));
    endtask

    // Stimulus: reset, directed worked case, then exhaustive sweep.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        x_dig = 8'b01111101;
        y_dig = 8'b01110111;
        @(posedge clk);
        @(negedge clk);
        // R7 worked case 6 + 5
        check(int'(sum_val) == 11, "R7 value", int'(sum_val), 11);
        check(sum_dig == 10'b0111110100, "R7 digits", int'(sum_dig), 10'b0111110100);
        compare();
        for (int c = 0; c < (1 << (4 * N)); c++) begin
            x_dig = c[2*N-1:0];
            y_dig = c[4*N-1:2*N];
            @(posedge clk);
            @(negedge clk);
            compare();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule